// File: doc/BRIEF.md
# Complementary PWM with Current-Status Duty Selection

This block generates three complementary PWM pairs (six outputs) from a single edge-aligned counter. Each pair owns two duty registers, an "A" register and a "B" register. A per-pair current-status input picks which one governs the pair. The input is sampled on the last clock of a period and held in a selection latch for the whole of the next period, so a pair never switches duty source inside a period. The top output of a pair is active while the counter is below the selected duty value. The bottom output is its complement. Separate polarity bits set the active level of the top outputs and of the bottom outputs.

Software loads the six duty values, the period and the polarity bits through a simple register write port. Duty and period writes go to shadow registers. They reach the counter and comparators only at a period boundary, or at any time while the block is disabled. The polarity bits act at once.

The sequencing is a two-state machine. `ST_IDLE` is the disabled state: the counter is held at 0, the outputs sit at their inactive levels, the selection latches are cleared, and the active registers track the shadows every cycle. `ST_RUN` counts periods. The transition `ST_IDLE -> ST_RUN` ("start") is taken on a clock edge where `en` is high. The transition `ST_RUN -> ST_IDLE` ("stop") is taken on a clock edge where `en` is low. Inside `ST_RUN`, the "wrap" event occurs on the last count of a period. It reloads the active registers and the selection latches.

Top module: `pwm_cs_top`

## Requirements
- R1: While running, the counter steps 0, 1, …, P−1 and then returns to 0, where P is the active period (write address 6). Each period therefore lasts P clocks.
- R2: The top output of pair p (pwm_o bit 2p) is active while the counter is below the selected duty value. The bottom output (bit 2p+1) is active exactly when the top output is not.
- R3: A selected duty of 0 keeps the top output inactive for the whole period. A duty greater than or equal to P keeps it active for the whole period.
- R4: Pair p has register A at write address 2p and register B at address 2p+1. A current-status bit cs_i[p] of 0 selects A and a 1 selects B. The input is sampled on the last clock of a period and governs the following period.
- R5: A change of cs_i during a period does not alter the duty used for that period.
- R6: In the first period after enable, every pair uses its A register, whatever the level of cs_i.
- R7: Configuration bit 0 (write address 7) makes the top outputs (bits 0, 2, 4) active-low. When the bit is clear, those outputs are active-high.
- R8: Configuration bit 1 (write address 7) makes the bottom outputs (bits 1, 3, 5) active-low. When the bit is clear, those outputs are active-high.
- R9: While disabled, the counter is 0, every output drives its inactive level (top outputs equal bit 0, bottom outputs equal bit 1), and the selection latches return to A. After reset all outputs are 0.
- R10: A duty or period write made while running takes effect only at the next wrap. The current period completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Write address: 0–5 duty, 6 period, 7 polarity |
| wr_data | input | CNT_W (8) | Write data |
| cs_i | input | NPAIR (3) | Current-status input, one bit per pair |
| pwm_o | output | 2·NPAIR (6) | PWM outputs; bit 2p top, bit 2p+1 bottom of pair p |

## Verification
The bench builds the block with its defaults: CNT_W = 8 and NPAIR = 3. With short periods of 4 to 10 clocks, a run of a few hundred cycles crosses dozens of wraps. It therefore repeatedly exercises shadow reloads, current-status sampling at the boundary, and the first period after enable. An 8-bit duty range lets the table place duties at 0, strictly inside the period, exactly equal to it and above it (up to 255). This covers both saturation cases of the comparator.

// File: rtl/pwm_cs_pkg.sv
package pwm_cs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Map an active flag onto a pin level for a given polarity bit.
    function automatic logic pin_level(input logic active, input logic neg);
        return active ^ neg;
    endfunction
endpackage

// File: rtl/pwm_cs_regs.sv
module pwm_cs_regs #(
    parameter int CNT_W = 8,
    parameter int NPAIR = 3,
    parameter int AW    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    input  logic                             load_i,
    output logic [2*NPAIR-1:0][CNT_W-1:0]    duty_act_o,
    output logic [CNT_W-1:0]                 per_act_o,
    output logic                             top_neg_o,
    output logic                             bot_neg_o
);
    localparam int            NDUTY = 2 * NPAIR;
    localparam logic [AW-1:0] A_PER = AW'(NDUTY);
    localparam logic [AW-1:0] A_CFG = AW'(NDUTY + 1);

    logic [NDUTY-1:0][CNT_W-1:0] duty_sh;
    logic [CNT_W-1:0]            per_sh;

    // Shadow copies and polarity: written by software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_sh   <= '0;
            per_sh    <= '0;
            top_neg_o <= 1'b0;
            bot_neg_o <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NDUTY; i++) begin
                if (wr_addr == AW'(i)) duty_sh[i] <= wr_data;
            end
            if (wr_addr == A_PER) per_sh <= wr_data;
            if (wr_addr == A_CFG) begin
                top_neg_o <= wr_data[0];
                bot_neg_o <= wr_data[1];
            end
        end
    end

    // Active copies: refreshed only on the load strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act_o <= '0;
            per_act_o  <= '0;
        end else if (load_i) begin
            duty_act_o <= duty_sh;
            per_act_o  <= per_sh;
        end
    end

    // R10: active values stay frozen between load strobes
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(per_act_o) && $stable(duty_act_o)));
endmodule

// File: rtl/pwm_cs_timer.sv
module pwm_cs_timer
    import pwm_cs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             wrap_o,
    output logic             load_o
);
    run_state_e state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;   // start
            ST_RUN:  if (!en) state_d = ST_IDLE;  // stop
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_o   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && en && !wrap_o) cnt_o <= cnt_o + CNT_W'(1);
            else                                    cnt_o <= '0;
        end
    end

    // Output decode of the state machine.
    always_comb begin
        run_o  = (state_q == ST_RUN);
        wrap_o = run_o && ((per_act == '0) || (cnt_o >= per_act - CNT_W'(1)));
        load_o = !run_o || wrap_o;
    end

    // R1: the count restarts from zero after the last count of a period
    p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && en) |=> (cnt_o == '0));
    // R1: inside a period the count advances by one
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && en && !wrap_o) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    // R9: disabling holds the counter at zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_o == '0));
endmodule

// File: rtl/pwm_cs_pair.sv
module pwm_cs_pair
    import pwm_cs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en,
    input  logic             wrap_i,
    input  logic             cs_i,
    input  logic [CNT_W-1:0] duty_a,
    input  logic [CNT_W-1:0] duty_b,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             top_neg,
    input  logic             bot_neg,
    output logic             top_o,
    output logic             bot_o
);
    logic             sel_q;
    logic [CNT_W-1:0] duty_sel;
    logic             top_act;

    // Selection latch: cleared while idle, reloaded only at a wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sel_q <= 1'b0;
        else if (!run_i || !en)    sel_q <= 1'b0;
        else if (wrap_i)           sel_q <= cs_i;
    end

    always_comb begin
        duty_sel = sel_q ? duty_b : duty_a;
        top_act  = run_i && (cnt_i < duty_sel);
        top_o    = run_i ? pin_level(top_act, top_neg)  : top_neg;
        bot_o    = run_i ? pin_level(!top_act, bot_neg) : bot_neg;
    end

    // R5: the selection cannot move inside a period
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && en && !wrap_i) |=> $stable(sel_q));
    // R6: after idle the A register is selected
    p_sel_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sel_q);
    // R2: top and bottom never share the same active state while running
    p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> ((top_o ^ top_neg) != (bot_o ^ bot_neg)));
endmodule

// File: rtl/pwm_cs_top.sv
module pwm_cs_top #(
    parameter int CNT_W = 8,
    parameter int NPAIR = 3,
    parameter int AW    = $clog2(2 * NPAIR + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [NPAIR-1:0]   cs_i,
    output logic [2*NPAIR-1:0] pwm_o
);
    logic [2*NPAIR-1:0][CNT_W-1:0] duty_act;
    logic [CNT_W-1:0]              per_act;
    logic [CNT_W-1:0]              cnt;
    logic                          top_neg, bot_neg;
    logic                          run, wrap, load;

    pwm_cs_regs #(.CNT_W(CNT_W), .NPAIR(NPAIR), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_i     (load),
        .duty_act_o (duty_act),
        .per_act_o  (per_act),
        .top_neg_o  (top_neg),
        .bot_neg_o  (bot_neg)
    );

    pwm_cs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .per_act (per_act),
        .cnt_o   (cnt),
        .run_o   (run),
        .wrap_o  (wrap),
        .load_o  (load)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_cs_pair #(.CNT_W(CNT_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (run),
            .en      (en),
            .wrap_i  (wrap),
            .cs_i    (cs_i[p]),
            .duty_a  (duty_act[2*p]),
            .duty_b  (duty_act[2*p+1]),
            .cnt_i   (cnt),
            .top_neg (top_neg),
            .bot_neg (bot_neg),
            .top_o   (pwm_o[2*p]),
            .bot_o   (pwm_o[2*p+1])
        );
    end

    // R9: the cycle after a stop, every output rests at its inactive level
    p_idle_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (pwm_o == {NPAIR{bot_neg, top_neg}}));
endmodule

// File: tb/tb_pwm_cs_top.sv
module tb_pwm_cs_top;
    localparam int CW = 8;
    localparam int NP = 3;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NP-1:0] cs_i = '0;
    logic [5:0]    pwm_o;

    pwm_cs_top #(.CNT_W(CW), .NPAIR(NP)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cs_i(cs_i), .pwm_o(pwm_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Behavioural reference state built from the requirements.
    logic [CW-1:0] m_sh [6];
    logic [CW-1:0] m_act[6];
    logic [CW-1:0] m_per_sh, m_per, m_cnt;
    logic          m_tneg, m_bneg, m_run;
    logic [2:0]    m_sel;

    // {period, duty5..duty0, cs, polarity}
    localparam logic [60:0] VEC [5] = '{
        {8'd10, 8'd12, 8'd10, 8'd5, 8'd0, 8'd7, 8'd3, 3'b000, 2'b00},
        {8'd10, 8'd12, 8'd10, 8'd5, 8'd0, 8'd7, 8'd3, 3'b111, 2'b00},
        {8'd6,  8'd0,  8'd6,  8'd5, 8'd1, 8'd4, 8'd2, 3'b101, 2'b01},
        {8'd7,  8'd7,  8'd0,  8'd3, 8'd3, 8'd1, 8'd5, 3'b010, 2'b10},
        {8'd4,  8'd255,8'd5,  8'd4, 8'd3, 8'd2, 8'd1, 3'b110, 2'b11}
    };

    function automatic logic [5:0] model_out();
        logic [5:0] r;
        for (int p = 0; p < 3; p++) begin
            if (!m_run) begin
                r[2*p]   = m_tneg;
                r[2*p+1] = m_bneg;
            end else begin
                logic [CW-1:0] d;
                logic          t;
                d = m_sel[p] ? m_act[2*p+1] : m_act[2*p];
                t = (m_cnt < d);
                r[2*p]   = t ^ m_tneg;
                r[2*p+1] = (!t) ^ m_bneg;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: advance the reference on the pre-edge inputs, then compare.
    task automatic tick(string tag);
        logic [CW-1:0] sh_old[6];
        logic [CW-1:0] per_sh_old;
        logic          wrap, load;
        for (int i = 0; i < 6; i++) sh_old[i] = m_sh[i];
        per_sh_old = m_per_sh;
        wrap = m_run && ((m_per == 0) || (m_cnt >= m_per - 8'd1));
        load = !m_run || wrap;
        @(posedge clk);
        if (wr_en) begin
            if (wr_addr < 3'd6) m_sh[wr_addr] = wr_data;
            else if (wr_addr == 3'd6) m_per_sh = wr_data;
            else begin m_tneg = wr_data[0]; m_bneg = wr_data[1]; end
        end
        if (load) begin
            for (int i = 0; i < 6; i++) m_act[i] = sh_old[i];
            m_per = per_sh_old;
        end
        if (!m_run || !en) m_sel = 3'b000;
        else if (wrap) m_sel = cs_i;
        m_cnt = (m_run && en && !wrap) ? m_cnt + 8'd1 : 8'd0;
        m_run = en;
        #1;
        check(tag, {26'd0, pwm_o}, {26'd0, model_out()});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    // Count cycles with pwm_o[0] high over one period of len clocks.
    task automatic period_hi(input int len, string tag, output int hi);
        hi = 0;
        for (int k = 0; k < len; k++) begin
            tick(tag);
            if (pwm_o[0]) hi++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int hi;
        for (int i = 0; i < 6; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        m_per_sh = '0; m_per = '0; m_cnt = '0;
        m_tneg = 0; m_bneg = 0; m_run = 0; m_sel = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R9 reset outputs", {26'd0, pwm_o}, 32'd0);

        // Table walk: every cycle compared with the reference.
        for (int v = 0; v < 5; v++) begin
            en = 1'b0;
            tick("R9 stop");
            for (int i = 0; i < 6; i++) wr(3'(i), VEC[v][5 + 8*i +: 8], "R10 load");
            wr(3'd6, VEC[v][60:53], "R1 period");
            wr(3'd7, {6'd0, VEC[v][1:0]}, "R7 R8 polarity");
            cs_i = VEC[v][4:2];
            en = 1'b1;
            for (int k = 0; k < 30; k++) tick("R1 R2 R3 R4 R7 R8 run");
        end

        // Directed: first period uses A, mid-period status changes, shadowing.
        en = 1'b0;
        tick("R9 stop");
        wr(3'd7, 8'd0, "R7 R8 clear");
        wr(3'd0, 8'd2, "R4 duty A");
        wr(3'd1, 8'd5, "R4 duty B");
        wr(3'd6, 8'd8, "R1 period 8");
        cs_i = 3'b111;
        en = 1'b1;
        period_hi(8, "R6", hi);
        check("R6 first period uses A", hi, 2);
        period_hi(3, "R5", hi);
        begin
            int hi2;
            cs_i = 3'b000;
            period_hi(5, "R5", hi2);
            check("R5 mid-period status change ignored", hi + hi2, 5);
        end
        period_hi(2, "R10", hi);
        begin
            int hi2, hi3;
            wr(3'd0, 8'd6, "R10 mid-period write");
            hi2 = pwm_o[0] ? 1 : 0;
            period_hi(5, "R10", hi3);
            check("R4 status low selects A", hi + hi2 + hi3, 2);
        end
        period_hi(8, "R10", hi);
        check("R10 new duty after wrap", hi, 6);

        // Duty saturation at and above the period.
        en = 1'b0;
        tick("R9 stop");
        wr(3'd0, 8'd8, "R3 duty eq period");
        en = 1'b1;
        period_hi(8, "R3", hi);
        check("R3 duty equal to period always active", hi, 8);
        en = 1'b0;
        tick("R9 stop");
        wr(3'd0, 8'd0, "R3 duty zero");
        en = 1'b1;
        period_hi(8, "R3", hi);
        check("R3 duty zero never active", hi, 0);

        // Polarity at the first count (count 0, duty A0 = 6 active).
        en = 1'b0;
        tick("R9 stop");
        wr(3'd0, 8'd6, "R7 duty");
        wr(3'd7, 8'd1, "R7 top negative");
        en = 1'b1;
        tick("R7");
        check("R7 active top low", {31'd0, pwm_o[0]}, 0);
        check("R8 inactive bottom low", {31'd0, pwm_o[1]}, 0);
        en = 1'b0;
        tick("R9 stop");
        wr(3'd7, 8'd2, "R8 bottom negative");
        en = 1'b1;
        tick("R8");
        check("R7 active top high", {31'd0, pwm_o[0]}, 1);
        check("R8 inactive bottom high", {31'd0, pwm_o[1]}, 1);

        // Disabled levels follow the polarity bits.
        en = 1'b0;
        tick("R9 stop");
        wr(3'd7, 8'd3, "R9 polarity");
        check("R9 idle levels both negative", {26'd0, pwm_o}, 32'h3f);
        wr(3'd7, 8'd1, "R9 polarity");
        check("R9 idle levels top negative", {26'd0, pwm_o}, 32'h15);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule